// File: doc/BRIEF.md
# Interlocked Four-Phase Parallel Bus Master

This block lets on-chip logic issue single reads and writes to a slow external controller over a parallel bus. A requester hands over one command at a time on a valid/ready port. The command carries an 8-bit address, a direction bit and 32 bits of write data. The master then drives the external side: separate active-low read and write strobes, an active-low chip-enable, the address lines and a bidirectional 32-bit data bus. The data bus is split into four byte lanes, with byte 0 on bits 7:0.

Each transfer is completed with a fully interlocked four-phase handshake on an active-low ready line from the slave. The direction strobe, the address and any write data are set up first. Chip-enable falls a configurable number of cycles later. The master then waits, with no fixed bound, for the slave to pull ready low, and releases all strobes together once it does. It accepts nothing new until the slave has raised ready again. Read data and ready come in through two-flop synchronizers. An optional watchdog abandons a transfer that the slave never acknowledges and reports an error instead. No command is taken before the slave's boot indication has been seen high.

Top module: `hsb_bus_master`

## Requirements
- R1: After reset, `bus_ce_n`, `bus_rd_n` and `bus_wr_n` are high, the master does not drive the data bus, `cmd_ready` is low and no response pulse is raised.
- R2: `cmd_ready` stays low, and no transfer starts, until `slave_booted` has been seen high. It goes high 3 clock edges after `slave_booted` rises, and the boot indication stays latched after that.
- R3: A command is accepted only on an edge where `cmd_valid` and `cmd_ready` are both high. On that edge the address is driven, and so is the direction strobe (`bus_rd_n` low when `cmd_write`=0, `bus_wr_n` low when `cmd_write`=1). `bus_ce_n` falls exactly SETUP_CYC edges later.
- R4: While `bus_ce_n` is low, exactly one of `bus_rd_n` and `bus_wr_n` is low, and the address and strobes do not change.
- R5: On a read the master never drives `bus_data`. The value the slave presents before ready falls is returned on `rsp_rdata` together with a one-cycle `rsp_rvalid` pulse. That pulse appears 3 clock edges after `bus_rdy_n` falls, in the same cycle as `bus_ce_n` and `bus_rd_n` go high.
- R6: On a write, `cmd_wdata` is driven on `bus_data` from acceptance until the strobes are released, with bits 7:0 carrying byte 0. A one-cycle `rsp_wdone` pulse appears 3 clock edges after `bus_rdy_n` falls, together with the release of `bus_ce_n` and `bus_wr_n`.
- R7: After the strobes are released, `cmd_ready` stays low for as long as `bus_rdy_n` is held low. It returns only after ready has been seen high again.
- R8: The slave may delay ready for any number of cycles below the watchdog limit, and the transfer still completes normally, with no error.
- R9: With WDOG_EN=1, if ready has not fallen WDOG_CYC edges after `bus_ce_n` fell, all strobes are released and a one-cycle `rsp_err` pulse is given in that cycle instead of `rsp_rvalid` or `rsp_wdone`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Requester offers a command |
| cmd_ready | output | 1 | Master idle and slave booted; command taken when both high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_rvalid |
| rsp_rvalid | output | 1 | One-cycle read completion |
| rsp_wdone | output | 1 | One-cycle write completion |
| rsp_err | output | 1 | One-cycle watchdog timeout |
| bus_ce_n | output | 1 | Active-low chip-enable |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | ADDR_W | External address lines |
| bus_data | inout | DATA_W | External data bus, byte 0 in bits 7:0 |
| bus_rdy_n | input | 1 | Active-low ready from slave, asynchronous |
| slave_booted | input | 1 | Slave boot indication, asynchronous |

## Verification
Every latency is measured on a free-running cycle counter that the bench samples at falling clock edges. Chip-enable must fall SETUP_CYC counts after the acceptance edge. Each response pulse must appear 3 counts after the slave model pulls ready low, because the ready line passes through two synchronizer flops and then one state register. A timeout error is due WDOG_CYC counts after chip-enable was first seen low. The bench compares each of these counts, the address and direction the slave model saw, and both data values against figures computed from the requirements. It also checks that each response pulse is gone one cycle later and that `cmd_ready` stays low for as long as the slave model holds ready low.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE
  } hsb_state_e;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsb_watchdog.sv
module hsb_watchdog #(
  parameter int EN    = 1,
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  generate
    if (EN != 0) begin : g_on
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
      end
      assign expired = run && (cnt == CW'(LIMIT - 1));
    end else begin : g_off
      logic unused_in;
      assign unused_in = clk ^ rst ^ clear ^ run;
      assign expired   = 1'b0 & unused_in;
    end
  endgenerate
endmodule

// File: rtl/hsb_bus_master.sv
module hsb_bus_master
  import hsb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SETUP_CYC = 2,
  parameter int WDOG_EN   = 1,
  parameter int WDOG_CYC  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_rvalid,
  output logic              rsp_wdone,
  output logic              rsp_err,
  output logic              bus_ce_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  input  logic              bus_rdy_n,
  input  logic              slave_booted
);
  localparam int SCNT_W = $clog2(SETUP_CYC + 1);

  hsb_state_e        state;
  logic [SCNT_W-1:0] scnt;
  logic              ce_n_q, rd_n_q, wr_n_q, oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q, rdata_q;
  logic              rvalid_q, wdone_q, err_q;
  logic              booted_q;

  logic              rdy_n_s, boot_s, wd_expired;
  logic [DATA_W-1:0] data_s;

  hsb_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst(rst), .d(bus_rdy_n), .q(rdy_n_s));

  hsb_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_boot_sync (
    .clk(clk), .rst(rst), .d(slave_booted), .q(boot_s));

  hsb_sync #(.W(DATA_W), .STAGES(2), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst(rst), .d(bus_data), .q(data_s));

  hsb_watchdog #(.EN(WDOG_EN), .LIMIT(WDOG_CYC)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .clear  (state != ST_STROBE),
    .run    ((state == ST_STROBE) && rdy_n_s),
    .expired(wd_expired)
  );

  assign cmd_ready = (state == ST_IDLE) && booted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      scnt     <= '0;
      ce_n_q   <= 1'b1;
      rd_n_q   <= 1'b1;
      wr_n_q   <= 1'b1;
      oe_q     <= 1'b0;
      addr_q   <= '0;
      dout_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      wdone_q  <= 1'b0;
      err_q    <= 1'b0;
      booted_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      wdone_q  <= 1'b0;
      err_q    <= 1'b0;
      booted_q <= booted_q | boot_s;
      case (state)
        ST_IDLE: begin
          if (cmd_valid && cmd_ready) begin
            addr_q <= cmd_addr;
            rd_n_q <= cmd_write;
            wr_n_q <= !cmd_write;
            oe_q   <= cmd_write;
            dout_q <= cmd_write ? cmd_wdata : '0;
            scnt   <= SCNT_W'(SETUP_CYC - 1);
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (scnt == '0) begin
            ce_n_q <= 1'b0;
            state  <= ST_STROBE;
          end else begin
            scnt <= scnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (!rdy_n_s || wd_expired) begin
            ce_n_q <= 1'b1;
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            oe_q   <= 1'b0;
            state  <= ST_RELEASE;
            if (!rdy_n_s) begin
              if (!rd_n_q) begin
                rdata_q  <= data_s;
                rvalid_q <= 1'b1;
              end else begin
                wdone_q <= 1'b1;
              end
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_RELEASE: begin
          if (rdy_n_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_data   = oe_q ? dout_q : {DATA_W{1'bz}};
  assign bus_ce_n   = ce_n_q;
  assign bus_rd_n   = rd_n_q;
  assign bus_wr_n   = wr_n_q;
  assign bus_addr   = addr_q;
  assign rsp_rdata  = rdata_q;
  assign rsp_rvalid = rvalid_q;
  assign rsp_wdone  = wdone_q;
  assign rsp_err    = err_q;
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              bus_ce_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              drv_oe,
  input logic              rsp_rvalid,
  input logic              rsp_wdone,
  input logic              rsp_err
);
  // R4: a single direction strobe during chip-enable
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !bus_ce_n |-> (bus_rd_n != bus_wr_n));

  // R4: address and strobes hold while chip-enable stays low
  a_r4_stable_cycle: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce_n && !$past(bus_ce_n)) |-> ($stable(bus_addr) && $stable(bus_rd_n) && $stable(bus_wr_n)));

  // R3: direction and address already set up before chip-enable falls
  a_r3_setup_before_ce: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ce_n) |-> ($stable(bus_rd_n) && $stable(bus_wr_n) && $stable(bus_addr) && (bus_rd_n != bus_wr_n)));

  // R5: read never drives the data bus
  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !drv_oe);

  // R5 R6 R9: response pulses last one cycle and never coincide
  a_r5_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_rvalid |=> !rsp_rvalid);
  a_r6_wdone_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_wdone |=> !rsp_wdone);
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_err |=> !rsp_err);
  a_r9_one_response: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_rvalid, rsp_wdone, rsp_err}) <= 1);

  // R5 R6 R9: strobes released in the cycle a response is given
  a_r6_release_with_resp: assert property (@(posedge clk) disable iff (rst)
    (rsp_rvalid || rsp_wdone || rsp_err) |-> (bus_ce_n && bus_rd_n && bus_wr_n && !drv_oe));

  // R7: readiness to accept only with the bus fully idle
  a_r7_idle_when_ready: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (bus_ce_n && bus_rd_n && bus_wr_n && !drv_oe));
endmodule

bind hsb_bus_master hsb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .bus_ce_n  (bus_ce_n),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_addr  (bus_addr),
  .drv_oe    (oe_q),
  .rsp_rvalid(rsp_rvalid),
  .rsp_wdone (rsp_wdone),
  .rsp_err   (rsp_err)
);

// File: tb/sim_hsb_bus_master.sv
module sim_hsb_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int DW   = 32;
  localparam int SETUP = 3;
  localparam int WDOG  = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_rvalid, rsp_wdone, rsp_err;
  logic          bus_ce_n, bus_rd_n, bus_wr_n;
  logic [AW-1:0] bus_addr;
  wire  [DW-1:0] bus_data;
  logic          bus_rdy_n = 1'b1;
  logic          slave_booted = 1'b0;

  // slave model state
  logic          sl_drv = 1'b0;
  logic [DW-1:0] sl_dout = '0;
  logic [DW-1:0] sl_rdata = '0;
  int            sl_delay = 0;
  int            sl_rel = 0;
  bit            sl_mute = 1'b0;
  bit            sl_hold = 1'b0;
  logic [AW-1:0] sl_addr;
  bit            sl_is_wr;
  logic [DW-1:0] sl_wdata;
  int            sl_ce_cyc = 0;
  int            sl_rdy_cyc = 0;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int strobe_viol = 0;
  bit done = 1'b0;

  assign bus_data = sl_drv ? sl_dout : {DW{1'bz}};

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hsb_bus_master #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP),
                   .WDOG_EN(1), .WDOG_CYC(WDOG)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid), .rsp_wdone(rsp_wdone),
    .rsp_err(rsp_err), .bus_ce_n(bus_ce_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rdy_n(bus_rdy_n), .slave_booted(slave_booted));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int resp_code(input bit is_wr, input bit mute);
    if (mute) return 3;
    return is_wr ? 2 : 1;
  endfunction

  // R4 monitor: one strobe only while chip-enable is low
  always @(negedge clk)
    if (!rst && !bus_ce_n && (bus_rd_n == bus_wr_n)) strobe_viol++;

  // slave model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !bus_ce_n) begin
        sl_ce_cyc = cyc;
        sl_addr   = bus_addr;
        sl_is_wr  = !bus_wr_n;
        sl_wdata  = bus_data;
        if (sl_mute) begin
          while (!bus_ce_n) @(negedge clk);
        end else begin
          repeat (sl_delay) @(negedge clk);
          if (!sl_is_wr) begin
            sl_dout = sl_rdata;
            sl_drv  = 1'b1;
            @(negedge clk);
          end
          bus_rdy_n  = 1'b0;
          sl_hold    = 1'b1;
          sl_rdy_cyc = cyc;
          while (!bus_ce_n) @(negedge clk);
          repeat (sl_rel) @(negedge clk);
          sl_drv    = 1'b0;
          bus_rdy_n = 1'b1;
          sl_hold   = 1'b0;
        end
      end
    end
  end

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [DW-1:0] rd, input int dly, input int rel, input bit mute);
    int acc, n, code, exp_code, rc;
    sl_rdata = rd;
    sl_delay = dly;
    sl_rel   = rel;
    sl_mute  = mute;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_addr  = a;
    cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_wdata = ~wd;
    n = 0;
    while (!(rsp_rvalid || rsp_wdone || rsp_err) && n < 1000) begin
      @(negedge clk);
      n++;
    end
    rc = cyc;
    code = rsp_err ? 3 : (rsp_wdone ? 2 : (rsp_rvalid ? 1 : 0));
    exp_code = resp_code(wr, mute);
    check(code == exp_code, mute ? "R9" : (wr ? "R6" : "R5"), "response kind", code, exp_code);
    check(sl_ce_cyc - acc == SETUP, "R3", "cycles from accept to ce fall", sl_ce_cyc - acc, SETUP);
    check(sl_addr == a && sl_is_wr == wr, "R3", "address/direction seen by slave",
          {23'd0, sl_is_wr, sl_addr}, {23'd0, wr, a});
    check(bus_ce_n && bus_rd_n && bus_wr_n, "R5", "strobes released with response",
          {bus_ce_n, bus_rd_n, bus_wr_n}, 3'b111);
    if (mute) begin
      check(rc - sl_ce_cyc == WDOG, "R9", "timeout latency", rc - sl_ce_cyc, WDOG);
    end else begin
      check(rc - sl_rdy_cyc == 3, "R8", "ready to response latency", rc - sl_rdy_cyc, 3);
      if (wr) check(sl_wdata == wd, "R6", "write data on bus", sl_wdata, wd);
      else    check(rsp_rdata == rd, "R5", "read data returned", rsp_rdata, rd);
    end
    @(negedge clk);
    check(!(rsp_rvalid || rsp_wdone || rsp_err), "R5", "response one cycle wide",
          {rsp_rvalid, rsp_wdone, rsp_err}, 0);
    while (sl_hold) begin
      check(!cmd_ready, "R7", "no accept while ready held", cmd_ready, 0);
      @(negedge clk);
    end
    n = 0;
    while (!cmd_ready && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(cmd_ready, "R7", "ready returns after release", cmd_ready, 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    // R1: reset state
    check(bus_ce_n && bus_rd_n && bus_wr_n, "R1", "strobes in reset",
          {bus_ce_n, bus_rd_n, bus_wr_n}, 3'b111);
    check(!cmd_ready && !rsp_rvalid && !rsp_wdone && !rsp_err, "R1", "idle outputs in reset",
          {cmd_ready, rsp_rvalid, rsp_wdone, rsp_err}, 0);
    rst = 1'b0;
    // R2: no transfer before boot
    cmd_valid = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cmd_ready || !bus_ce_n || !bus_rd_n || !bus_wr_n) n++;
    end
    check(n == 0, "R2", "activity before boot", n, 0);
    cmd_valid = 1'b0;
    slave_booted = 1'b1;
    n = 0;
    while (!cmd_ready && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == 3, "R2", "boot to cmd_ready latency", n, 3);
    slave_booted = 1'b0;
    repeat (5) @(negedge clk);
    check(cmd_ready, "R2", "boot stays latched", cmd_ready, 1);

    // directed corner cases
    xfer(1'b0, 8'h00, '0, 32'hDEAD_BEEF, 0, 0, 1'b0);           // fastest read
    xfer(1'b1, 8'hFF, 32'h4433_22A5, '0, 0, 0, 1'b0);            // write, byte lane 0 = A5
    xfer(1'b0, 8'h5A, '0, 32'h0123_4567, 55, 12, 1'b0);          // R8 long wait read
    xfer(1'b1, 8'hA5, 32'hCAFE_F00D, '0, 55, 0, 1'b0);           // R8 long wait write
    xfer(1'b0, 8'h11, '0, 32'h1, 0, 0, 1'b1);                    // R9 timeout read
    xfer(1'b1, 8'h22, 32'h2, '0, 0, 0, 1'b1);                    // R9 timeout write
    xfer(1'b0, 8'h33, '0, 32'hFFFF_FFFF, 2, 5, 1'b0);            // recovery after timeout

    // constrained random
    for (int t = 0; t < 40; t++) begin
      xfer(1'($urandom), 8'($urandom), $urandom, $urandom,
           int'($urandom_range(0, 40)), int'($urandom_range(0, 10)), 1'b0);
    end

    check(strobe_viol == 0, "R4", "cycles with illegal strobe pair", strobe_viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule